// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block sits behind a byte-oriented serial receiver and places each received byte into the buffer of the current receive descriptor. Descriptors form a ring. A host owns a descriptor while its empty bit is clear. The engine owns it while that bit is set. Each descriptor carries a 16-bit status word and a 16-bit length word. Every descriptor also has a fixed buffer of `BUF_BYTES` bytes in an internal RAM.

The receiver front end delivers, with each byte, an end-of-frame marker and the error flags for that byte. The engine closes a descriptor in three cases: at end of frame, when its byte count reaches the configured limit, or on any error. On a close it writes back status and length. It then steps to the next descriptor, or returns to index 0 when the wrap bit is set.

Two sticky events report activity, and each can raise the interrupt line through its own enable:
- The buffer event signals that a descriptor with its interrupt bit set was closed.
- The busy event signals that a byte was dropped for lack of an owned descriptor.

A single host port reads and writes the descriptor table and reads the buffer bytes.

Top module: `rxbd_ring`

## Requirements
- R1: After reset every descriptor status and length reads 0, `evt` is 0 and `irq` is 0.
- R2: Status layout: bit0 empty, bit2 wrap, bit3 interrupt, bit4 last, bit5 first, bit6 continuous, bit8 DPLL error, bit11 non-octet, bit12 parity, bit13 CRC, bit14 overrun, bit15 carrier lost, other bits 0. A byte flagged end-of-frame closes the descriptor with last set and length equal to the frame's total byte count.
- R3: A descriptor whose byte count reaches the limit (`cfg_max_len`, or `BUF_BYTES` when it is 0 or larger) closes with last clear and length equal to its byte count. The frame then continues in the next descriptor. Only the descriptor holding a frame's first byte gets the first bit.
- R4: After a close the engine moves to index 0 if the closed descriptor has its wrap bit set; otherwise it moves to the next index.
- R5: Closing a descriptor whose interrupt bit is set sets `evt[0]`. A dropped byte sets `evt[1]`. `irq` is high exactly when an event bit is set whose `irq_en` bit was set at the updating edge.
- R6: With continuous mode set and no error, the empty bit stays set on close, so the descriptor is reused on the next pass. Any error clears it.
- R7: A byte with a parity error is stored, closes the descriptor as its last byte with the parity bit set, and later bytes go to the next descriptor.
- R8: Error flags for CRC, non-octet, DPLL, overrun and carrier loss close the descriptor and set their status bits. CRC bytes are stored like any data.
- R9: A byte arriving when no descriptor is open and the current one has empty clear is dropped. The buffer and the descriptor are unchanged, the index does not advance, and an end-of-frame on such a byte still ends the frame.
- R10: `host_rdata` shows the addressed word one cycle after the address. Addresses 0..2*NDESC-1 are descriptor words (index*2, +1 for length). Address 32+index*8+offset reads a buffer byte, and host writes there are ignored.
- R11: Bits of `evt_clr` clear the matching event bits; a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe from receiver |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Byte ends the frame |
| rx_par_err | input | 1 | Parity error on this byte |
| rx_crc_err | input | 1 | CRC mismatch at frame end |
| rx_nonoct | input | 1 | Frame bit count not a multiple of 8 |
| rx_dpll_err | input | 1 | Missing transition in decoder |
| rx_ovr | input | 1 | Receiver overrun |
| rx_cd_lost | input | 1 | Carrier lost during frame |
| cfg_max_len | input | $clog2(BUF_BYTES)+1 | Buffer byte limit |
| irq_en | input | 2 | Interrupt enables for evt bits |
| evt_clr | input | 2 | Clear strobes for evt bits |
| evt | output | 2 | Sticky events: bit0 buffer closed, bit1 busy |
| irq | output | 1 | Interrupt request |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 1+$clog2(NDESC)+$clog2(BUF_BYTES) | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after address |

## Verification
A byte presented before a clock edge is stored, and the closing write-back lands in the descriptor table, at that same edge. `evt` and `irq` also update at that edge. A host read of the result therefore returns its value at the edge after the address is applied. The bench drives every input on the falling edge. It samples events one falling edge after a byte and reads descriptors with one edge of read latency. This places every comparison after the register that produces the value.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int ST_E  = 0;
  localparam int ST_W  = 2;
  localparam int ST_I  = 3;
  localparam int ST_L  = 4;
  localparam int ST_F  = 5;
  localparam int ST_CM = 6;
  localparam int ST_DE = 8;
  localparam int ST_NO = 11;
  localparam int ST_PR = 12;
  localparam int ST_CR = 13;
  localparam int ST_OV = 14;
  localparam int ST_CD = 15;

  typedef struct packed {
    logic eof;
    logic par;
    logic crc;
    logic nonoct;
    logic dpll;
    logic ovr;
    logic cd;
  } rx_flags_t;
endpackage

// File: rtl/rxbd_bufmem.sv
module rxbd_bufmem #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxbd_table.sv
module rxbd_table #(
  parameter int NDESC = 4,
  parameter int DIW   = $clog2(NDESC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        h_we,
  input  logic [DIW-1:0]              h_idx,
  input  logic                        h_word,
  input  logic [15:0]                 h_wdata,
  input  logic                        e_we,
  input  logic [DIW-1:0]              e_idx,
  input  logic [15:0]                 e_st,
  input  logic [15:0]                 e_len,
  output logic [NDESC-1:0][15:0]      st_o,
  output logic [NDESC-1:0][15:0]      len_o,
  output logic [NDESC-1:0]            own_o
);
  import rxbd_pkg::*;

  logic [NDESC-1:0][15:0] st_q, len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      len_q <= '0;
    end else begin
      if (h_we) begin
        if (h_word) len_q[h_idx] <= h_wdata;
        else        st_q[h_idx]  <= h_wdata;
      end
      if (e_we) begin
        st_q[e_idx]  <= e_st;
        len_q[e_idx] <= e_len;
      end
    end
  end

  assign st_o  = st_q;
  assign len_o = len_q;

  for (genvar g = 0; g < NDESC; g++) begin : g_own
    assign own_o[g] = st_q[g][ST_E];
  end
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine #(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8,
  parameter int DIW       = $clog2(NDESC),
  parameter int BAW       = $clog2(BUF_BYTES),
  parameter int CW        = BAW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  rxbd_pkg::rx_flags_t    fl,
  input  logic [CW-1:0]          lim,
  input  logic [NDESC-1:0][15:0] desc_st,
  output logic                   buf_we,
  output logic [DIW+BAW-1:0]     buf_addr,
  output logic [7:0]             buf_wdata,
  output logic                   wb_en,
  output logic [DIW-1:0]         wb_idx,
  output logic [15:0]            wb_st,
  output logic [15:0]            wb_len,
  output logic                   wb_err,
  output logic                   accept,
  output logic                   rxb_set,
  output logic                   busy_set,
  output logic [DIW-1:0]         cur_o,
  output logic                   open_o,
  output logic                   own_o,
  output logic [CW-1:0]          cnt_o
);
  import rxbd_pkg::*;

  logic [DIW-1:0] cur_q;
  logic           open_q, inf_q, first_q;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [15:0]    fcnt_q, fcnt_n;
  logic [15:0]    cur_st;
  logic           own, err, first_n, close;

  always_comb begin
    cur_st   = desc_st[cur_q];
    own      = cur_st[ST_E];
    accept   = rx_valid && (open_q || own);
    busy_set = rx_valid && !accept;
    err      = fl.par | fl.crc | fl.nonoct | fl.dpll | fl.ovr | fl.cd;
    cnt_n    = cnt_q + 1'b1;
    fcnt_n   = (inf_q ? fcnt_q : 16'd0) + 16'd1;
    first_n  = open_q ? first_q : !inf_q;
    close    = accept && (fl.eof || err || cnt_n == lim);

    wb_st        = '0;
    wb_st[ST_E]  = cur_st[ST_CM] && !err;
    wb_st[ST_W]  = cur_st[ST_W];
    wb_st[ST_I]  = cur_st[ST_I];
    wb_st[ST_L]  = fl.eof;
    wb_st[ST_F]  = first_n;
    wb_st[ST_CM] = cur_st[ST_CM];
    wb_st[ST_DE] = fl.dpll;
    wb_st[ST_NO] = fl.nonoct;
    wb_st[ST_PR] = fl.par;
    wb_st[ST_CR] = fl.crc;
    wb_st[ST_OV] = fl.ovr;
    wb_st[ST_CD] = fl.cd;
    wb_len       = fl.eof ? fcnt_n : {{(16-CW){1'b0}}, cnt_n};
    wb_en        = close;
    wb_idx       = cur_q;
    wb_err       = err;
    rxb_set      = close && cur_st[ST_I];

    buf_we    = accept;
    buf_addr  = {cur_q, cnt_q[BAW-1:0]};
    buf_wdata = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      open_q  <= 1'b0;
      inf_q   <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
      fcnt_q  <= '0;
    end else if (accept) begin
      open_q  <= !close;
      cnt_q   <= close ? '0 : cnt_n;
      first_q <= first_n;
      inf_q   <= !fl.eof;
      fcnt_q  <= fl.eof ? 16'd0 : fcnt_n;
      if (close) begin
        if (cur_st[ST_W] || cur_q == DIW'(NDESC-1)) cur_q <= '0;
        else                                       cur_q <= cur_q + 1'b1;
      end
    end else if (busy_set && fl.eof) begin
      inf_q  <= 1'b0;
      fcnt_q <= '0;
    end
  end

  assign cur_o  = cur_q;
  assign open_o = open_q;
  assign own_o  = own;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          rx_valid,
  input  logic [7:0]                                    rx_data,
  input  logic                                          rx_eof,
  input  logic                                          rx_par_err,
  input  logic                                          rx_crc_err,
  input  logic                                          rx_nonoct,
  input  logic                                          rx_dpll_err,
  input  logic                                          rx_ovr,
  input  logic                                          rx_cd_lost,
  input  logic [$clog2(BUF_BYTES):0]                    cfg_max_len,
  input  logic [1:0]                                    irq_en,
  input  logic [1:0]                                    evt_clr,
  output logic [1:0]                                    evt,
  output logic                                          irq,
  input  logic                                          host_we,
  input  logic [$clog2(NDESC)+$clog2(BUF_BYTES):0]      host_addr,
  input  logic [15:0]                                   host_wdata,
  output logic [15:0]                                   host_rdata
);
  import rxbd_pkg::*;

  localparam int DIW = $clog2(NDESC);
  localparam int BAW = $clog2(BUF_BYTES);
  localparam int CW  = BAW + 1;
  localparam int HAW = 1 + DIW + BAW;

  rx_flags_t fl;
  assign fl = '{eof: rx_eof, par: rx_par_err, crc: rx_crc_err, nonoct: rx_nonoct,
                dpll: rx_dpll_err, ovr: rx_ovr, cd: rx_cd_lost};

  logic [CW-1:0] lim;
  assign lim = (cfg_max_len == '0 || cfg_max_len > CW'(BUF_BYTES)) ? CW'(BUF_BYTES) : cfg_max_len;

  logic                   sel_buf, desc_hit;
  logic [DIW-1:0]         h_idx;
  assign sel_buf  = host_addr[HAW-1];
  assign desc_hit = !sel_buf && (host_addr[HAW-2:DIW+1] == '0);
  assign h_idx    = host_addr[DIW:1];

  logic [NDESC-1:0][15:0] desc_st, desc_len;
  logic [NDESC-1:0]       desc_e;
  logic                   buf_we, wb_en, wb_err, accept, rxb_set, busy_set;
  logic                   eng_open, cur_own;
  logic [DIW+BAW-1:0]     buf_addr;
  logic [7:0]             buf_wdata, buf_rd;
  logic [DIW-1:0]         wb_idx, cur_idx;
  logic [15:0]            wb_st, wb_len;
  logic [CW-1:0]          cnt;

  rxbd_engine #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_eng (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .fl(fl),
    .lim(lim), .desc_st(desc_st), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .wb_en(wb_en), .wb_idx(wb_idx), .wb_st(wb_st),
    .wb_len(wb_len), .wb_err(wb_err), .accept(accept), .rxb_set(rxb_set),
    .busy_set(busy_set), .cur_o(cur_idx), .open_o(eng_open), .own_o(cur_own),
    .cnt_o(cnt)
  );

  rxbd_table #(.NDESC(NDESC)) u_tab (
    .clk(clk), .rst(rst), .h_we(host_we && desc_hit), .h_idx(h_idx),
    .h_word(host_addr[0]), .h_wdata(host_wdata), .e_we(wb_en), .e_idx(wb_idx),
    .e_st(wb_st), .e_len(wb_len), .st_o(desc_st), .len_o(desc_len), .own_o(desc_e)
  );

  rxbd_bufmem #(.DEPTH(NDESC*BUF_BYTES)) u_mem (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(host_addr[DIW+BAW-1:0]), .rdata(buf_rd)
  );

  logic        sel_q;
  logic [15:0] desc_rd_q;
  logic [1:0]  evt_q, evt_n;
  logic        irq_q;

  always_comb evt_n = (evt_q & ~evt_clr) | {busy_set, rxb_set};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      desc_rd_q <= '0;
      evt_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      sel_q     <= sel_buf;
      desc_rd_q <= !desc_hit ? 16'h0 : (host_addr[0] ? desc_len[h_idx] : desc_st[h_idx]);
      evt_q     <= evt_n;
      irq_q     <= |(evt_n & irq_en);
    end
  end

  assign host_rdata = sel_q ? {8'h00, buf_rd} : desc_rd_q;
  assign evt        = evt_q;
  assign irq        = irq_q;
endmodule

// File: rtl/rxbd_ring_chk.sv
module rxbd_ring_chk #(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8,
  parameter int DIW       = $clog2(NDESC),
  parameter int CW        = $clog2(BUF_BYTES) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_par_err,
  input logic             eng_open,
  input logic             cur_own,
  input logic             accept,
  input logic [DIW-1:0]   cur_idx,
  input logic [CW-1:0]    cnt,
  input logic             wb_en,
  input logic             wb_err,
  input logic [DIW-1:0]   wb_idx,
  input logic [15:0]      wb_st,
  input logic [NDESC-1:0] desc_e,
  input logic [1:0]       evt,
  input logic [1:0]       irq_en,
  input logic             irq
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(evt & $past(irq_en))); // R5

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !eng_open && !cur_own) |=> ($stable(cur_idx) && !eng_open)); // R9

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(BUF_BYTES)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_st[2]) |=> (cur_idx == '0)); // R4

  AST_ERR_DROPS_OWN: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_err) |=> !desc_e[$past(wb_idx)]); // R6

  AST_PAR_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (accept && rx_par_err) |-> wb_en); // R7
endmodule

bind rxbd_ring rxbd_ring_chk #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
  .eng_open(eng_open), .cur_own(cur_own), .accept(accept), .cur_idx(cur_idx),
  .cnt(cnt), .wb_en(wb_en), .wb_err(wb_err), .wb_idx(wb_idx), .wb_st(wb_st),
  .desc_e(desc_e), .evt(evt), .irq_en(irq_en), .irq(irq)
);

// File: tb/rxbd_ring_tb.sv
`timescale 1ns/100ps
module rxbd_ring_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_eof = 0, rx_par_err = 0, rx_crc_err = 0;
  logic        rx_nonoct = 0, rx_dpll_err = 0, rx_ovr = 0, rx_cd_lost = 0;
  logic [7:0]  rx_data = 0;
  logic [3:0]  cfg_max_len = 4'd4;
  logic [1:0]  irq_en = 2'b01, evt_clr = 2'b00, evt;
  logic        irq, host_we = 0;
  logic [5:0]  host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxbd_ring #(.NDESC(4), .BUF_BYTES(8)) u_dut (.*);

  // {eof, parity, data}
  localparam logic [9:0] VEC [11] = '{
    10'h011, 10'h022, 10'h233,
    10'h0A0, 10'h0A1, 10'h0A2, 10'h0A3, 10'h0A4, 10'h2A5,
    10'h155, 10'h266};

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hwr(logic [5:0] a, logic [15:0] d);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hrd(logic [5:0] a, output logic [15:0] d);
    host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic send(logic [7:0] d, logic eof, logic par, logic crc, logic no,
                      logic dp, logic ov, logic cd);
    rx_valid = 1; rx_data = d; rx_eof = eof; rx_par_err = par; rx_crc_err = crc;
    rx_nonoct = no; rx_dpll_err = dp; rx_ovr = ov; rx_cd_lost = cd;
    @(negedge clk);
    rx_valid = 0; rx_eof = 0; rx_par_err = 0; rx_crc_err = 0;
    rx_nonoct = 0; rx_dpll_err = 0; rx_ovr = 0; rx_cd_lost = 0;
  endtask

  task automatic chk_desc(string req, int idx, logic [15:0] st, logic [15:0] ln);
    logic [15:0] v;
    hrd(6'(idx*2), v);     chk(req, v, st);
    hrd(6'(idx*2 + 1), v); chk(req, v, ln);
  endtask

  task automatic chk_buf(string req, int idx, int off, logic [7:0] exp);
    logic [15:0] v;
    hrd(6'(32 + idx*8 + off), v); chk(req, v, {8'h00, exp});
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    hrd(6'd0, v); chk("R1 status", v, 16'h0000);
    hrd(6'd7, v); chk("R1 length", v, 16'h0000);
    chk("R1 evt", {14'h0, evt}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    hwr(6'd0, 16'h0009);  // E|I
    hwr(6'd2, 16'h0001);  // E
    hwr(6'd4, 16'h0041);  // E|CM
    hwr(6'd6, 16'h000D);  // E|W|I

    for (int i = 0; i < 11; i++)
      send(VEC[i][7:0], VEC[i][9], VEC[i][8], 0, 0, 0, 0, 0);

    chk("R5 evt both", {14'h0, evt}, 16'h0003);
    chk("R5 irq enabled rxb", {15'h0, irq}, 16'h0001);
    chk_desc("R2 eof close", 0, 16'h0038, 16'd3);
    chk_desc("R3 limit close", 1, 16'h0020, 16'd4);
    chk_desc("R3 R6 frame total cm", 2, 16'h0051, 16'd6);
    chk_desc("R7 R4 parity wrap", 3, 16'h102C, 16'd1);
    chk_buf("R10 buf d0", 0, 0, 8'h11);
    chk_buf("R2 buf d0", 0, 2, 8'h33);
    chk_buf("R3 buf d1", 1, 3, 8'hA3);
    chk_buf("R3 buf d2", 2, 1, 8'hA5);
    chk_buf("R7 bad byte last", 3, 0, 8'h55);
    chk_buf("R9 dropped byte", 0, 1, 8'h22);

    // R11: clear events
    evt_clr = 2'b11; @(negedge clk); evt_clr = 2'b00;
    chk("R11 evt cleared", {14'h0, evt}, 16'h0);
    chk("R11 irq low", {15'h0, irq}, 16'h0);

    // R10: writes to buffer region ignored
    hwr(6'd32, 16'h00EE);
    chk_buf("R10 buf write ignored", 0, 0, 8'h11);

    // R8 CRC with continuous mode -> empty cleared
    irq_en = 2'b10;
    hwr(6'd0, 16'h0041);
    send(8'h77, 1, 0, 1, 0, 0, 0, 0);
    chk_desc("R8 R6 crc error", 0, 16'h2070, 16'd1);
    chk("R5 no rxb when I clear", {14'h0, evt}, 16'h0);

    // R8 remaining error bits
    hwr(6'd2, 16'h0001);
    send(8'h88, 1, 0, 0, 1, 1, 1, 1);
    chk_desc("R8 error bits", 1, 16'hC930, 16'd1);

    // R6 continuous reuse of d2
    send(8'h99, 1, 0, 0, 0, 0, 0, 0);
    chk_desc("R6 reuse", 2, 16'h0071, 16'd1);
    chk_buf("R6 reuse data", 2, 0, 8'h99);

    // R9 drop at d3 (not owned): busy event, irq via enable bit 1
    send(8'hBB, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 busy evt", {14'h0, evt}, 16'h0002);
    chk("R5 irq busy", {15'h0, irq}, 16'h0001);
    chk_desc("R9 d3 unchanged", 3, 16'h102C, 16'd1);
    chk_buf("R9 d3 buf unchanged", 3, 0, 8'h55);

    // R11 set wins over clear
    evt_clr = 2'b10; rx_valid = 1; rx_data = 8'hCC;
    @(negedge clk); evt_clr = 2'b00; rx_valid = 0;
    chk("R11 set wins", {14'h0, evt}, 16'h0002);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule